// File: doc/BRIEF.md
# Symbol Timing Loop Filter and Oscillator

This block closes the digital half of a symbol timing recovery loop. An external timing detector hands it one signed timing error per symbol over a valid/ready stream. Each accepted error goes through a proportional-plus-integral filter. Both gains come from one packed byte, and each gain is a right-shift amount. The integral term is an 8-bit signed register that software can read to estimate the symbol-rate offset once the loop has settled.

The filter output, sign-extended, trims the step of a 24-bit phase accumulator. The nominal step is held in three byte registers. Every time the accumulator wraps, the block raises an interpolation strobe for one cycle and presents the top accumulator bits as the fractional interval for a downstream interpolating filter.

The error input never applies back-pressure. `err_ready` is held high, and an error is consumed in any cycle where `err_valid` is high. There is no way to stall the detector, so a detector that drops `err_valid` simply leaves the filter state unchanged. A byte-wide register port has a synchronous write strobe and a combinational read. It gives access to the frequency bytes, the gain byte and the integrator.

Top module: `sym_timing_loop`

## Requirements
- R1: After reset, the registers read back as follows: gain byte 0x48, integrator 0x0A, frequency bytes 0xD3 / 0x11 / 0x0C (low / middle / high). `interp_stb` and `interp_mu` are both 0.
- R2: The read map is: 0x8A frequency bits 7:0, 0x8B bits 15:8, 0x8C bits 23:16, 0x8D gain byte, 0x8E integrator (two's complement). Every other address reads 0.
- R3: A write to any address other than 0x8A to 0x8D changes no register. This includes 0x8E, since the integrator is read-only from the port.
- R4: On each cycle with `err_valid` high, the integrator takes the error arithmetically right-shifted by the gain byte's bits 3:0. In cycles without `err_valid` it holds.
- R5: The integrator saturates at +127 and -128 instead of wrapping.
- R6: On each accepted error, the filter output becomes the updated integrator plus the error arithmetically right-shifted by the gain byte's bits 7:4. It holds between symbols.
- R7: Every clock, the accumulator adds (frequency + sign-extended filter output) modulo 2^24, using the values held before that edge. `interp_stb` is high for exactly the cycles after an edge where this addition carried out of bit 23.
- R8: When `interp_stb` is high, `interp_mu` equals accumulator bits 23:16 after the wrap. It holds otherwise.
- R9: A frequency byte write is used by the accumulator from the next clock edge onward.
- R10: `err_ready` is high in every cycle, so an error offered with `err_valid` is never stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_valid | input | 1 | Timing error present this cycle |
| err_ready | output | 1 | Always high; the block accepts every error |
| err_data | input | ERR_W | Signed timing error |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| interp_stb | output | 1 | One-cycle strobe on accumulator wrap |
| interp_mu | output | MU_W | Fractional interval, accumulator top bits |

## Verification
Assertions check the following properties on every cycle:
- The integrator and filter output hold when no error is offered.
- The integrator stays pinned at its upper limit under a non-negative error.
- The strobe coincides exactly with a decrease of the accumulator.
- The fractional output moves only together with the strobe.
- A low-byte frequency write lands on the next edge.
- An unmapped write leaves every register unchanged.

The bench's reference model compares the strobe, the interval and the readback on every clock. Only those scenarios can show the following:
- The exact arithmetic of the two shift paths for many gain settings.
- Saturation at both ends.
- Strobe spacing after retuning the frequency.
- Readback of the full map, including the reset values.

// File: rtl/sym_timing_pkg.sv
package sym_timing_pkg;
  localparam int REG_W = 8;
  localparam int INTEG_W = 8;

  localparam logic [REG_W-1:0] ADDR_FREQ_BASE = 8'h8A;
  localparam logic [REG_W-1:0] ADDR_GAIN      = 8'h8D;
  localparam logic [REG_W-1:0] ADDR_INTEG     = 8'h8E;

  localparam logic [REG_W-1:0] GAIN_RESET  = 8'h48;
  localparam logic [INTEG_W-1:0] INTEG_RESET = 8'h0A;

  typedef struct packed {
    logic [3:0] prop_shift;
    logic [3:0] int_shift;
  } gain_t;
endpackage

// File: rtl/sym_timing_regs.sv
module sym_timing_regs
  import sym_timing_pkg::*;
#(
  parameter int NCO_W = 24,
  parameter logic [NCO_W-1:0] FREQ_INIT = 24'h0C11D3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   addr,
  input  logic [REG_W-1:0]   wdata,
  input  logic [INTEG_W-1:0] integ_rd,
  output logic [REG_W-1:0]   rdata,
  output logic [NCO_W-1:0]   freq_o,
  output gain_t              gain_o
);
  localparam int FREQ_BYTES = NCO_W / REG_W;

  logic [REG_W-1:0] freq_b [FREQ_BYTES];
  gain_t gain_q;
  logic  addr_hit;

  for (genvar b = 0; b < FREQ_BYTES; b++) begin : g_freq
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        freq_b[b] <= FREQ_INIT[b*REG_W +: REG_W];
      end else if (wr_en && addr == ADDR_FREQ_BASE + REG_W'(b)) begin
        freq_b[b] <= wdata;
      end
    end
    assign freq_o[b*REG_W +: REG_W] = freq_b[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= GAIN_RESET;
    end else if (wr_en && addr == ADDR_GAIN) begin
      gain_q <= wdata;
    end
  end
  assign gain_o = gain_q;

  always_comb begin
    rdata    = '0;
    addr_hit = 1'b0;
    for (int b = 0; b < FREQ_BYTES; b++) begin
      if (addr == ADDR_FREQ_BASE + REG_W'(b)) begin
        rdata    = freq_b[b];
        addr_hit = 1'b1;
      end
    end
    if (addr == ADDR_GAIN) begin
      rdata    = gain_q;
      addr_hit = 1'b1;
    end
    if (addr == ADDR_INTEG) begin
      rdata = integ_rd;
    end
  end

  // R9: a low frequency byte write is visible after the next edge
  p_freq_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_FREQ_BASE) |=> freq_o[REG_W-1:0] == $past(wdata));

  // R3: writes outside the writable map change nothing
  p_unmapped_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_hit) |=> ($stable(freq_o) && $stable(gain_o)));
endmodule

// File: rtl/sym_loop_filter.sv
module sym_loop_filter
  import sym_timing_pkg::*;
#(
  parameter int ERR_W = 8,
  localparam int WIDE_W = (ERR_W > INTEG_W) ? ERR_W : INTEG_W,
  localparam int CTRL_W = WIDE_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     err_valid,
  input  logic signed [ERR_W-1:0]  err_data,
  input  gain_t                    gain,
  output logic signed [INTEG_W-1:0] integ_o,
  output logic signed [CTRL_W-1:0]  ctrl_o
);
  localparam int SUM_W = WIDE_W + 2;
  localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'(2 ** (INTEG_W - 1) - 1);
  localparam logic signed [SUM_W-1:0] SAT_LO = ~SAT_HI;
  localparam logic signed [INTEG_W-1:0] INT_TOP = INTEG_W'(2 ** (INTEG_W - 1) - 1);

  logic signed [INTEG_W-1:0] integ_q, integ_nxt;
  logic signed [CTRL_W-1:0]  ctrl_q, ctrl_nxt;
  logic signed [ERR_W-1:0]   int_term, prop_term;
  logic signed [SUM_W-1:0]   int_sum;

  always_comb begin
    int_term  = err_data >>> gain.int_shift;
    prop_term = err_data >>> gain.prop_shift;
    int_sum   = SUM_W'(integ_q) + SUM_W'(int_term);
    if (int_sum > SAT_HI) begin
      integ_nxt = INT_TOP;
    end else if (int_sum < SAT_LO) begin
      integ_nxt = ~INT_TOP;
    end else begin
      integ_nxt = int_sum[INTEG_W-1:0];
    end
    ctrl_nxt = CTRL_W'(integ_nxt) + CTRL_W'(prop_term);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q <= INTEG_RESET;
      ctrl_q  <= '0;
    end else if (err_valid) begin
      integ_q <= integ_nxt;
      ctrl_q  <= ctrl_nxt;
    end
  end

  assign integ_o = integ_q;
  assign ctrl_o  = ctrl_q;

  // R4: integrator only moves on an accepted error
  p_integ_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !err_valid |=> $stable(integ_q));

  // R6: filter output held between symbols
  p_ctrl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !err_valid |=> $stable(ctrl_q));

  // R5: a full integrator stays full under a non-negative error
  p_sat_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && integ_q == INT_TOP && !err_data[ERR_W-1]) |=> integ_q == INT_TOP);
endmodule

// File: rtl/sym_timing_nco.sv
module sym_timing_nco #(
  parameter int NCO_W  = 24,
  parameter int CTRL_W = 9,
  parameter int MU_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCO_W-1:0]         freq,
  input  logic signed [CTRL_W-1:0] ctrl,
  output logic                     stb_o,
  output logic [MU_W-1:0]          mu_o
);
  logic [NCO_W-1:0] acc_q, acc_nxt, step;
  logic             carry;
  logic             stb_q;
  logic [MU_W-1:0]  mu_q;

  always_comb begin
    step             = freq + NCO_W'(ctrl);
    {carry, acc_nxt} = {1'b0, acc_q} + {1'b0, step};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      stb_q <= 1'b0;
      mu_q  <= '0;
    end else begin
      acc_q <= acc_nxt;
      stb_q <= carry;
      if (carry) begin
        mu_q <= acc_nxt[NCO_W-1 -: MU_W];
      end
    end
  end

  assign stb_o = stb_q;
  assign mu_o  = mu_q;

  // R7: strobe marks exactly the edges where the accumulator wrapped downward
  p_wrap_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q == (acc_q < $past(acc_q)));

  // R8: the interval only moves together with a strobe
  p_mu_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_q |-> $stable(mu_q));
endmodule

// File: rtl/sym_timing_loop.sv
module sym_timing_loop
  import sym_timing_pkg::*;
#(
  parameter int ERR_W = 8,
  parameter int NCO_W = 24,
  parameter int MU_W  = 8,
  parameter logic [NCO_W-1:0] FREQ_INIT = 24'h0C11D3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_valid,
  output logic             err_ready,
  input  logic [ERR_W-1:0] err_data,
  input  logic             reg_wr,
  input  logic [7:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             interp_stb,
  output logic [MU_W-1:0]  interp_mu
);
  localparam int WIDE_W = (ERR_W > INTEG_W) ? ERR_W : INTEG_W;
  localparam int CTRL_W = WIDE_W + 1;

  logic [NCO_W-1:0]          freq;
  gain_t                     gain;
  logic signed [INTEG_W-1:0] integ;
  logic signed [CTRL_W-1:0]  ctrl;
  logic                      err_take;

  assign err_ready = 1'b1;
  assign err_take  = err_valid && err_ready;

  sym_timing_regs #(.NCO_W(NCO_W), .FREQ_INIT(FREQ_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .integ_rd(integ), .rdata(reg_rdata), .freq_o(freq), .gain_o(gain)
  );

  sym_loop_filter #(.ERR_W(ERR_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .err_valid(err_take), .err_data(err_data),
    .gain(gain), .integ_o(integ), .ctrl_o(ctrl)
  );

  sym_timing_nco #(.NCO_W(NCO_W), .CTRL_W(CTRL_W), .MU_W(MU_W)) u_nco (
    .clk(clk), .rst_n(rst_n), .freq(freq), .ctrl(ctrl),
    .stb_o(interp_stb), .mu_o(interp_mu)
  );
endmodule

// File: tb/sym_timing_loop_tb_top.sv
module sym_timing_loop_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       err_valid = 1'b0;
  logic       err_ready;
  logic [7:0] err_data = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       interp_stb;
  logic [7:0] interp_mu;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  int m_freq, m_gain, m_integ, m_ctrl, m_acc, m_stb, m_mu;

  always #10 clk = ~clk;

  sym_timing_loop dut_i (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_ready(err_ready),
    .err_data(err_data), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .interp_stb(interp_stb), .interp_mu(interp_mu)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_read(input int a);
    case (a)
      'h8A: return m_freq & 'hFF;
      'h8B: return (m_freq >> 8) & 'hFF;
      'h8C: return (m_freq >> 16) & 'hFF;
      'h8D: return m_gain;
      'h8E: return m_integ & 'hFF;
      default: return 0;
    endcase
  endfunction

  // per-clock reference model and comparison
  always @(posedge clk) begin
    int s, e, ni;
    if (!rst_n) begin
      m_freq = 'h0C11D3; m_gain = 'h48; m_integ = 'h0A;
      m_ctrl = 0; m_acc = 0; m_stb = 0; m_mu = 0;
    end else begin
      s = m_acc + ((m_freq + m_ctrl) & 'hFFFFFF);
      m_stb = (s >> 24) & 1;
      m_acc = s & 'hFFFFFF;
      if (m_stb != 0) m_mu = m_acc >> 16;
      if (err_valid) begin
        e  = int'($signed(err_data));
        ni = m_integ + (e >>> (m_gain & 15));
        if (ni > 127) ni = 127;
        if (ni < -128) ni = -128;
        m_integ = ni;
        m_ctrl  = ni + (e >>> (m_gain >> 4));
      end
      if (reg_wr) begin
        case (reg_addr)
          8'h8A: m_freq = (m_freq & 'hFFFF00) | int'(reg_wdata);
          8'h8B: m_freq = (m_freq & 'hFF00FF) | (int'(reg_wdata) << 8);
          8'h8C: m_freq = (m_freq & 'h00FFFF) | (int'(reg_wdata) << 16);
          8'h8D: m_gain = int'(reg_wdata);
          default: ;
        endcase
      end
    end
    #5;
    if (rst_n && !done) begin
      check("R7 R9 strobe", int'(interp_stb), m_stb);
      check("R8 interval", int'(interp_mu), m_mu);
      check((reg_addr == 8'h8E) ? "R4 R6 integrator read" : "R2 read",
            int'(reg_rdata), model_read(int'(reg_addr)));
      check("R10 ready", int'(err_ready), 1);
    end
  end

  task automatic drive(input bit v, input int e, input bit w, input int a, input int d);
    @(negedge clk);
    err_valid = v; err_data = 8'(e);
    reg_wr = w; reg_addr = 8'(a); reg_wdata = 8'(d);
  endtask

  task automatic read_check(input string tag, input int a, input int exp);
    drive(0, 0, 0, a, 0);
    @(posedge clk); #6;
    check(tag, int'(reg_rdata), exp);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values at the ports
    check("R1 stb", int'(interp_stb), 0);
    check("R1 mu", int'(interp_mu), 0);
    read_check("R1 gain", 'h8D, 'h48);
    read_check("R1 integrator", 'h8E, 'h0A);
    read_check("R1 freq lo", 'h8A, 'hD3);
    read_check("R1 freq mid", 'h8B, 'h11);
    read_check("R1 freq hi", 'h8C, 'h0C);
    read_check("R2 unmapped read", 'h8F, 0);
    // R4 R6 R7: random errors with default gains, sparse validity
    for (int i = 0; i < 600; i++)
      drive(($urandom % 3) != 0, $urandom % 256, 0, 'h8A + ($urandom % 6), 0);
    // several gain settings
    for (int g = 0; g < 6; g++) begin
      drive(0, 0, 1, 'h8D, (g * 'h23 + 'h11) & 'hFF);
      for (int i = 0; i < 150; i++)
        drive($urandom % 2, ($urandom % 64) - 32, 0, 'h8E, 0);
    end
    // R5: saturation at both limits with zero shifts
    drive(0, 0, 1, 'h8D, 'h00);
    for (int i = 0; i < 3; i++) drive(1, 127, 0, 'h8E, 0);
    read_check("R5 upper limit", 'h8E, 'h7F);
    for (int i = 0; i < 3; i++) drive(1, -128, 0, 'h8E, 0);
    read_check("R5 lower limit", 'h8E, 'h80);
    // R3: ignored writes, incl. the read-only integrator
    drive(0, 0, 1, 'h8E, 'h55);
    drive(0, 0, 1, 'h8F, 'hAA);
    drive(0, 0, 1, 'h89, 'hAA);
    drive(0, 0, 1, 'h00, 'hAA);
    read_check("R3 integrator unchanged", 'h8E, 'h80);
    read_check("R3 gain unchanged", 'h8D, 'h00);
    read_check("R3 freq lo unchanged", 'h8A, 'hD3);
    read_check("R3 freq hi unchanged", 'h8C, 'h0C);
    // R9: retune the nominal step, strobe spacing follows next edge
    drive(1, 0, 1, 'h8D, 'hFF);
    drive(1, 0, 0, 'h8D, 0);
    drive(0, 0, 1, 'h8C, 'h40);
    drive(0, 0, 1, 'h8B, 'h00);
    drive(0, 0, 1, 'h8A, 'h00);
    read_check("R9 freq hi readback", 'h8C, 'h40);
    for (int i = 0; i < 40; i++) drive(0, 0, 0, 'h8C, 0);
    drive(0, 0, 1, 'h8C, 'hF0);
    for (int i = 0; i < 40; i++) drive(0, 0, 0, 'h8C, 0);
    // random register writes mixed with errors
    for (int i = 0; i < 500; i++)
      drive($urandom % 2, $urandom % 256, ($urandom % 8) == 0, 'h88 + ($urandom % 8), $urandom % 256);
    drive(0, 0, 0, 0, 0);
    @(posedge clk); #6;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule